// File: doc/BRIEF.md
# Armed Parallel Flash Programming Controller

This block sits on the device side of a parallel programming port. An external programmer uses it while the processor core is held in reset. The programmer presents a 4-bit command code, a 16-bit address and an 8-bit data byte. Erase and program commands are captured on the high-to-low edge of a program strobe. Read commands return data combinationally and ignore the strobe.

The controller refuses all work until the programmer has armed it. Arming takes an identification read followed by a fixed delay. Once armed, the controller does the following:
- It tracks which of two memory blocks is selected.
- It enforces a security lock made of three security bits.
- It holds two configuration bits: a start-up bit and a clock-mode bit.
- It runs erases and byte programs against two small internal byte arrays. Each operation lasts a parameterised number of cycles.
- It reports progress on a ready/busy output.

The sequencer has five states:
- OFF: outside programming mode.
- WAIT_ID: in programming mode, waiting for the identification read.
- ARMING: counting the arming delay.
- READY: armed and idle.
- BUSY: an operation is running.

Its transitions are:
- enter: OFF to WAIT_ID, when programming mode starts.
- id_seen: WAIT_ID to ARMING, when the read-ID code appears.
- armed: ARMING to READY, after ARM_CYC cycles.
- start: READY to BUSY, on a strobe fall carrying an accepted command.
- done: BUSY to READY, when the operation counter expires.
- leave: any state to OFF, when programming mode ends. This aborts any running operation.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Programming mode starts only when `mode_en_n` goes from 1 to 0 while `hold_rst` is 1, and it lasts while both conditions hold. Outside the mode, `rdata` is 00h and `ready` is 1. Leaving the mode drops the armed state, so the controller must be armed again on the next entry.
- R2: Before arming completes, every strobed command is ignored (`ready` stays 1) and a verify read returns 00h. Arming completes ARM_CYC cycles after the read-ID code 0000b is first seen in the mode.
- R3: A read with code 0000b returns data selected by the address:
  - 0030h returns BFh.
  - 0031h returns DEV_ID.
  - 0060h returns {5'b0, SC0, SB1, SB2}.
  - 0061h returns {6'b0, CLK, SB3}.
  - Any other address returns 00h.
  These reads work whether or not the controller is armed.
- R4: The command codes are: read-ID 0000b, chip erase 0001b, block erase 1101b, sector erase 1011b, byte program 1110b, verify 1100b, configure 1001b, SB1 1111b, SB2 0011b, SB3 0101b. Any other code is ignored.
- R5: Under code 1001b, addr[15:8] selects the action:
  - 55h selects block 0.
  - A5h selects block 1.
  - 5Ah sets SC0.
  - AAh sets the clock-mode bit CLK.
  - Any other value is ignored.
  Block 1 is selected on every entry into programming mode.
- R6: With block 1 selected, an address below BLK1_LIMIT (2000h) goes to block 1 at index addr[B1_AW-1:0]. Every other address goes to block 0 at index addr[B0_AW-1:0].
- R7: Byte program stores old AND data at the mapped byte. A verify read returns the stored byte.
- R8: Sector erase sets the 128-byte sector holding the mapped address to FFh and leaves other bytes unchanged. Block erase sets the whole selected block to FFh and leaves the other block unchanged.
- R9: Chip erase does the following, even when the device is locked:
  - Sets both blocks to FFh.
  - Clears SB1, SB2, SB3 and SC0.
  - Keeps CLK.
  - Returns the selection to block 1.
  Only chip erase can clear a security bit.
- R10: While any security bit is set, block erase, sector erase and byte program are ignored, and verify returns 00h. Security-bit, configuration and select commands are still accepted.
- R11: `ready` goes low on the cycle after the strobe-fall edge of an accepted command. It stays low for exactly the operation's cycle count (T_CE, T_BE, T_SE, T_PB, T_SEL or T_SB), then returns high.
- R12: While busy, every strobe is ignored. A verify read returns bit 3 equal to the complement of bit 3 of the data loaded by the running byte program, with all other bits 0. During any other operation the verify read returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low block reset; arrays to FFh, bits cleared |
| hold_rst | input | 1 | Device reset pin level; must be 1 for programming mode |
| mode_en_n | input | 1 | Programming mode request, active low, entered on its falling edge |
| strobe_n | input | 1 | Program strobe; erase/program commands start on its fall |
| cmd | input | 4 | Command code |
| addr | input | 16 | Address; high byte also carries the configure key |
| wdata | input | 8 | Data for byte program |
| rdata | output | 8 | Combinational read data |
| ready | output | 1 | 1 = idle, 0 = operation running |

## Verification
The bench first looks for commands leaking through before arming, both before the identification read and during the arming delay. A controller that armed early would start a chip erase or a program there, which shows up as a busy pulse. It then probes the low-8 KB aliasing: a byte written at 2010h while block 1 is selected must land in block 0. A design that applied the selection to the whole address space would show that byte in block 1 instead.

Lock handling is checked from both sides. Program and erase must give no busy pulse while locked. Chip erase must still run, clear the lock, keep the clock-mode bit and return to block 1; a design that blocked chip erase or forgot the reselection fails the readbacks that follow. Busy-time polling is checked for both its program and erase forms. A strobe issued mid-erase must leave the array untouched. After an exit, a re-entry without a new identification read must refuse work.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_WAIT_ID,
        S_ARMING,
        S_READY,
        S_BUSY
    } fcc_state_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CE,
        OP_BE,
        OP_SE,
        OP_PB,
        OP_SEL0,
        OP_SEL1,
        OP_SC0,
        OP_SC1,
        OP_SB1,
        OP_SB2,
        OP_SB3
    } fcc_op_e;

    localparam logic [3:0] C_RDID = 4'b0000;
    localparam logic [3:0] C_CE   = 4'b0001;
    localparam logic [3:0] C_BE   = 4'b1101;
    localparam logic [3:0] C_SE   = 4'b1011;
    localparam logic [3:0] C_PB   = 4'b1110;
    localparam logic [3:0] C_VFY  = 4'b1100;
    localparam logic [3:0] C_CFG  = 4'b1001;
    localparam logic [3:0] C_SB1  = 4'b1111;
    localparam logic [3:0] C_SB2  = 4'b0011;
    localparam logic [3:0] C_SB3  = 4'b0101;

    localparam logic [7:0] K_SEL0 = 8'h55;
    localparam logic [7:0] K_SEL1 = 8'hA5;
    localparam logic [7:0] K_SC0  = 8'h5A;
    localparam logic [7:0] K_SC1  = 8'hAA;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fcc_mode_det.sv
module fcc_mode_det (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_rst,
    input  logic mode_en_n,
    input  logic strobe_n,
    output logic in_mode,
    output logic strobe_fall
);
    logic men_q;
    logic stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            men_q   <= 1'b1;
            stb_q   <= 1'b1;
            in_mode <= 1'b0;
        end else begin
            men_q <= mode_en_n;
            stb_q <= strobe_n;
            if (!hold_rst || mode_en_n)
                in_mode <= 1'b0;
            else if (men_q)
                in_mode <= 1'b1;
        end
    end

    assign strobe_fall = in_mode && stb_q && !strobe_n;

    // R1: entry needs the request low with the reset pin high
    p_entry_cond_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_mode) |-> $past(!mode_en_n && hold_rst));

endmodule

// File: rtl/fcc_bank.sv
module fcc_bank #(
    parameter int AW     = 8,
    parameter int SEC_AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          clr_all,
    input  logic          clr_sec,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_idx] <= mem[wr_idx] & wr_data;
        end else if (clr_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (clr_sec) begin
            for (int i = 0; i < DEPTH; i++)
                if ((i >> SEC_AW) == int'(wr_idx >> SEC_AW)) mem[i] <= 8'hFF;
        end
    end

    assign rd_data = mem[rd_idx];

    // R8: a whole-bank clear leaves both ends erased
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          IDX_W      = 9,
    parameter logic [15:0] BLK1_LIMIT = 16'h2000,
    parameter int          ARM_CYC    = 1000,
    parameter int          T_CE       = 3000,
    parameter int          T_BE       = 2000,
    parameter int          T_SE       = 600,
    parameter int          T_PB       = 50,
    parameter int          T_SEL      = 4,
    parameter int          T_SB       = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_mode,
    input  logic              strobe_fall,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ready,
    output logic              armed,
    output logic              busy,
    output logic              poll_bit,
    output logic              sel1,
    output logic              lock,
    output logic              sc0,
    output logic              sc1,
    output logic [2:0]        sb,
    output logic              ap_wr,
    output logic              ap_ce,
    output logic              ap_be,
    output logic              ap_se,
    output logic              ap_blk1,
    output logic [IDX_W-1:0]  ap_idx,
    output logic [7:0]        ap_data
);
    localparam int unsigned T_MAX = max2(max2(max2(T_CE, T_BE), max2(T_SE, T_PB)),
                                         max2(T_SEL, T_SB));
    localparam int CW  = $clog2(T_MAX + 1);
    localparam int ACW = $clog2(ARM_CYC + 1);

    fcc_state_e      state, st_nx;
    fcc_op_e         dec_op, op_q;
    logic [CW-1:0]   busy_cnt;
    logic [ACW-1:0]  arm_cnt;
    logic            apply;

    function automatic logic [CW-1:0] dur(input fcc_op_e op);
        unique case (op)
            OP_CE:                 return CW'(T_CE - 1);
            OP_BE:                 return CW'(T_BE - 1);
            OP_SE:                 return CW'(T_SE - 1);
            OP_PB:                 return CW'(T_PB - 1);
            OP_SEL0, OP_SEL1:      return CW'(T_SEL - 1);
            default:               return CW'(T_SB - 1);
        endcase
    endfunction

    // command decode, with lock refusal folded in
    always_comb begin
        dec_op = OP_NONE;
        unique case (cmd)
            C_CE:  dec_op = OP_CE;
            C_BE:  if (!lock) dec_op = OP_BE;
            C_SE:  if (!lock) dec_op = OP_SE;
            C_PB:  if (!lock) dec_op = OP_PB;
            C_SB1: dec_op = OP_SB1;
            C_SB2: dec_op = OP_SB2;
            C_SB3: dec_op = OP_SB3;
            C_CFG: begin
                unique case (addr[ADDR_W-1 -: 8])
                    K_SEL0:  dec_op = OP_SEL0;
                    K_SEL1:  dec_op = OP_SEL1;
                    K_SC0:   dec_op = OP_SC0;
                    K_SC1:   dec_op = OP_SC1;
                    default: dec_op = OP_NONE;
                endcase
            end
            default: dec_op = OP_NONE;
        endcase
    end

    // next state
    always_comb begin
        st_nx = state;
        if (!in_mode) begin
            st_nx = S_OFF;                                   // leave
        end else begin
            unique case (state)
                S_OFF:     st_nx = S_WAIT_ID;                // enter
                S_WAIT_ID: if (cmd == C_RDID) st_nx = S_ARMING;       // id_seen
                S_ARMING:  if (arm_cnt == ACW'(ARM_CYC - 1)) st_nx = S_READY; // armed
                S_READY:   if (strobe_fall && dec_op != OP_NONE) st_nx = S_BUSY; // start
                S_BUSY:    if (busy_cnt == '0) st_nx = S_READY;      // done
                default:   st_nx = S_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= st_nx;
    end

    assign apply = (state == S_BUSY) && (busy_cnt == '0) && in_mode;

    // datapath and persistent bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt  <= '0;
            busy_cnt <= '0;
            op_q     <= OP_NONE;
            ap_idx   <= '0;
            ap_data  <= '0;
            ap_blk1  <= 1'b0;
            sel1     <= 1'b1;
            sb       <= '0;
            sc0      <= 1'b0;
            sc1      <= 1'b0;
        end else begin
            arm_cnt <= (state == S_ARMING) ? arm_cnt + 1'b1 : '0;
            if (state == S_READY && st_nx == S_BUSY) begin
                op_q     <= dec_op;
                ap_idx   <= addr[IDX_W-1:0];
                ap_data  <= wdata;
                ap_blk1  <= (dec_op == OP_BE) ? sel1 : (sel1 && addr < BLK1_LIMIT);
                busy_cnt <= dur(dec_op);
            end else if (state == S_BUSY && busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (state == S_OFF) sel1 <= 1'b1;
            if (apply) begin
                unique case (op_q)
                    OP_CE: begin
                        sb   <= '0;
                        sc0  <= 1'b0;
                        sel1 <= 1'b1;
                    end
                    OP_SEL0: sel1  <= 1'b0;
                    OP_SEL1: sel1  <= 1'b1;
                    OP_SC0:  sc0   <= 1'b1;
                    OP_SC1:  sc1   <= 1'b1;
                    OP_SB1:  sb[0] <= 1'b1;
                    OP_SB2:  sb[1] <= 1'b1;
                    OP_SB3:  sb[2] <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        ready    = (state != S_BUSY);
        armed    = (state == S_READY);
        busy     = (state == S_BUSY);
        lock     = |sb;
        poll_bit = (op_q == OP_PB) ? ~ap_data[3] : 1'b0;
        ap_wr    = apply && (op_q == OP_PB);
        ap_ce    = apply && (op_q == OP_CE);
        ap_be    = apply && (op_q == OP_BE);
        ap_se    = apply && (op_q == OP_SE);
    end

    // R2: work can only start from the armed idle state
    p_busy_from_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && $past(state) != S_BUSY) |-> $past(state) == S_READY);

    // R10: no array write commits while locked
    p_no_write_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ap_wr |-> !lock);

    // R9: the lock only drops through a chip erase
    p_unlock_by_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> $past(ap_ce));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fcc_pkg::*;
#(
    parameter int          B0_AW      = 9,
    parameter int          B1_AW      = 8,
    parameter int          SEC_AW     = 7,
    parameter logic [15:0] BLK1_LIMIT = 16'h2000,
    parameter logic [7:0]  DEV_ID     = 8'h9D,
    parameter int          ARM_CYC    = 1000,
    parameter int          T_CE       = 3000,
    parameter int          T_BE       = 2000,
    parameter int          T_SE       = 600,
    parameter int          T_PB       = 50,
    parameter int          T_SEL      = 4,
    parameter int          T_SB       = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_rst,
    input  logic        mode_en_n,
    input  logic        strobe_n,
    input  logic [3:0]  cmd,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        ready
);
    localparam int ADDR_W = 16;
    localparam int IDX_W  = (B0_AW > B1_AW) ? B0_AW : B1_AW;

    logic             in_mode, strobe_fall;
    logic             armed, busy, poll_bit, sel1, lock, sc0, sc1;
    logic [2:0]       sb;
    logic             ap_wr, ap_ce, ap_be, ap_se, ap_blk1;
    logic [IDX_W-1:0] ap_idx;
    logic [7:0]       ap_data;
    logic [7:0]       b0_rd, b1_rd;
    logic             rd_blk1;

    fcc_mode_det u_mode (
        .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .mode_en_n(mode_en_n),
        .strobe_n(strobe_n), .in_mode(in_mode), .strobe_fall(strobe_fall)
    );

    fcc_seq #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BLK1_LIMIT(BLK1_LIMIT), .ARM_CYC(ARM_CYC),
        .T_CE(T_CE), .T_BE(T_BE), .T_SE(T_SE), .T_PB(T_PB), .T_SEL(T_SEL), .T_SB(T_SB)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .in_mode(in_mode), .strobe_fall(strobe_fall),
        .cmd(cmd), .addr(addr), .wdata(wdata),
        .ready(ready), .armed(armed), .busy(busy), .poll_bit(poll_bit),
        .sel1(sel1), .lock(lock), .sc0(sc0), .sc1(sc1), .sb(sb),
        .ap_wr(ap_wr), .ap_ce(ap_ce), .ap_be(ap_be), .ap_se(ap_se),
        .ap_blk1(ap_blk1), .ap_idx(ap_idx), .ap_data(ap_data)
    );

    fcc_bank #(.AW(B0_AW), .SEC_AW(SEC_AW)) u_bank0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ap_wr && !ap_blk1),
        .clr_all(ap_ce || (ap_be && !ap_blk1)),
        .clr_sec(ap_se && !ap_blk1),
        .wr_idx(ap_idx[B0_AW-1:0]), .wr_data(ap_data),
        .rd_idx(addr[B0_AW-1:0]), .rd_data(b0_rd)
    );

    fcc_bank #(.AW(B1_AW), .SEC_AW(SEC_AW)) u_bank1 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ap_wr && ap_blk1),
        .clr_all(ap_ce || (ap_be && ap_blk1)),
        .clr_sec(ap_se && ap_blk1),
        .wr_idx(ap_idx[B1_AW-1:0]), .wr_data(ap_data),
        .rd_idx(addr[B1_AW-1:0]), .rd_data(b1_rd)
    );

    assign rd_blk1 = sel1 && (addr < BLK1_LIMIT);

    // combinational read path
    always_comb begin
        rdata = 8'h00;
        if (in_mode) begin
            unique case (cmd)
                C_RDID: begin
                    unique case (addr)
                        16'h0030: rdata = 8'hBF;
                        16'h0031: rdata = DEV_ID;
                        16'h0060: rdata = {5'b0, sc0, sb[0], sb[1]};
                        16'h0061: rdata = {6'b0, sc1, sb[2]};
                        default:  rdata = 8'h00;
                    endcase
                end
                C_VFY: begin
                    if (busy)
                        rdata = {4'b0, poll_bit, 3'b0};
                    else if (armed && !lock)
                        rdata = rd_blk1 ? b1_rd : b0_rd;
                end
                default: rdata = 8'h00;
            endcase
        end
    end

    // R11: busy only ever begins right after a strobe fall
    p_busy_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(strobe_fall));

    // R1: dropping the reset pin silences the read port
    p_quiet_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_rst |=> rdata == 8'h00);

endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;
    localparam int ARM = 20, TCE = 40, TBE = 30, TSE = 20, TPB = 8, TSEL = 3, TSB = 6;
    localparam logic [7:0] DEV = 8'h9D;
    localparam logic [3:0] RDID = 4'b0000, CE = 4'b0001, BE = 4'b1101, SE = 4'b1011,
                           PB = 4'b1110, VFY = 4'b1100, CFG = 4'b1001, SB1 = 4'b1111,
                           SB2 = 4'b0011, SB3 = 4'b0101, IDLE = 4'b1010;

    logic        clk = 1'b0, rst_n = 1'b0, hold_rst = 1'b0, mode_en_n = 1'b1, strobe_n = 1'b1;
    logic [3:0]  cmd = IDLE;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    typedef struct { logic [7:0] exp; string tag; } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    flash_prog_ctrl #(.ARM_CYC(ARM), .T_CE(TCE), .T_BE(TBE), .T_SE(TSE), .T_PB(TPB),
                      .T_SEL(TSEL), .T_SB(TSB), .DEV_ID(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .mode_en_n(mode_en_n),
        .strobe_n(strobe_n), .cmd(cmd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data, compare at the falling edge
    always @(negedge clk) begin
        exp_t it;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            chk(rdata == it.exp, it.tag, int'(rdata), int'(it.exp));
        end
    end

    task automatic rd(input logic [3:0] c, input logic [15:0] a, input logic [7:0] e,
                      input string tag);
        exp_t it;
        @(negedge clk);
        cmd = c; addr = a;
        @(posedge clk);
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(posedge clk);
    endtask

    task automatic pulse(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd = c; addr = a; wdata = d; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!ready && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic op(input logic [3:0] c, input logic [15:0] a, input logic [7:0] d,
                      input int exp_n, input string tag);
        int n;
        pulse(c, a, d);
        wait_rdy(n);
        chk(n == exp_n, tag, n, exp_n);
        cmd = IDLE;
    endtask

    task automatic enter_mode();
        @(negedge clk);
        hold_rst = 1'b1; mode_en_n = 1'b1;
        repeat (2) @(negedge clk);
        mode_en_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic arm();
        rd(RDID, 16'h0030, 8'hBF, "R3 id byte");
        cmd = IDLE;
        repeat (ARM + 5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
        rst_n = 1'b1;
        rd(VFY, 16'h0000, 8'h00, "R1 out of mode");
        // request low before reset pin high: no entry
        @(negedge clk); mode_en_n = 1'b0;
        @(negedge clk); hold_rst = 1'b1;
        repeat (3) @(negedge clk);
        rd(RDID, 16'h0030, 8'h00, "R1 no entry without fall");
        cmd = IDLE;
        enter_mode();
        // unarmed
        op(CE, 16'h0000, 8'h00, 0, "R2 ignored before id");
        rd(VFY, 16'h0005, 8'h00, "R2 verify unarmed");
        rd(RDID, 16'h0030, 8'hBF, "R3 mfr id");
        rd(RDID, 16'h0031, DEV, "R3 dev id");
        op(PB, 16'h0005, 8'h00, 0, "R2 ignored during delay");
        repeat (ARM + 5) @(negedge clk);
        // program, AND semantics
        op(PB, 16'h0005, 8'hA5, TPB, "R11 program time");
        rd(VFY, 16'h0005, 8'hA5, "R7 program");
        op(PB, 16'h0005, 8'h0F, TPB, "R7 second program");
        rd(VFY, 16'h0005, 8'h05, "R7 and");
        // block selection
        op(CFG, 16'h5500, 8'h00, TSEL, "R5 select0 time");
        rd(VFY, 16'h0005, 8'hFF, "R5 block0 erased");
        op(PB, 16'h0005, 8'h3C, TPB, "R6 program block0");
        rd(VFY, 16'h0005, 8'h3C, "R6 block0 data");
        op(CFG, 16'hA500, 8'h00, TSEL, "R5 select1");
        rd(VFY, 16'h0005, 8'h05, "R5 block1 data");
        // high addresses always hit block 0
        op(PB, 16'h2010, 8'h77, TPB, "R6 high program");
        rd(VFY, 16'h2010, 8'h77, "R6 high read");
        rd(VFY, 16'h0010, 8'hFF, "R6 block1 untouched");
        op(CFG, 16'h5500, 8'h00, TSEL, "R5 select0");
        rd(VFY, 16'h0010, 8'h77, "R6 landed in block0");
        op(CFG, 16'hA500, 8'h00, TSEL, "R5 select1");
        // sector erase
        op(PB, 16'h0085, 8'h11, TPB, "R7 program sector1");
        rd(VFY, 16'h0085, 8'h11, "R7 sector1 data");
        op(SE, 16'h0080, 8'h00, TSE, "R8 sector time");
        rd(VFY, 16'h0085, 8'hFF, "R8 sector erased");
        rd(VFY, 16'h0005, 8'h05, "R8 other sector kept");
        // program polling
        pulse(PB, 16'h0006, 8'h30);
        rd(VFY, 16'h0006, 8'h08, "R12 program poll");
        wait_rdy(n);
        rd(VFY, 16'h0006, 8'h30, "R7 after poll");
        // block erase
        op(BE, 16'h0000, 8'h00, TBE, "R8 block erase time");
        rd(VFY, 16'h0005, 8'hFF, "R8 block1 erased");
        rd(VFY, 16'h2010, 8'h77, "R8 block0 kept");
        // erase polling, strobe ignored while busy
        pulse(BE, 16'h0000, 8'h00);
        rd(VFY, 16'h0000, 8'h00, "R12 erase poll");
        pulse(PB, 16'h0007, 8'h00);
        wait_rdy(n);
        rd(VFY, 16'h0007, 8'hFF, "R12 busy strobe ignored");
        // configuration bits
        op(CFG, 16'h5A00, 8'h00, TSB, "R5 sc0 time");
        rd(RDID, 16'h0060, 8'h04, "R3 sc0 readback");
        op(CFG, 16'hAA00, 8'h00, TSB, "R5 clk bit");
        rd(RDID, 16'h0061, 8'h02, "R3 clk readback");
        // unknown codes
        op(IDLE, 16'h0000, 8'h00, 0, "R4 unknown code");
        op(CFG, 16'h1200, 8'h00, 0, "R4 unknown key");
        // lock
        op(SB2, 16'h0000, 8'h00, TSB, "R10 sb2 time");
        rd(RDID, 16'h0060, 8'h05, "R3 sb2 readback");
        op(PB, 16'h0001, 8'h00, 0, "R10 program refused");
        op(SE, 16'h0000, 8'h00, 0, "R10 sector refused");
        op(BE, 16'h0000, 8'h00, 0, "R10 block refused");
        rd(VFY, 16'h2010, 8'h00, "R10 verify blocked");
        op(SB1, 16'h0000, 8'h00, TSB, "R10 sb1 accepted");
        rd(RDID, 16'h0060, 8'h07, "R3 sb1 readback");
        op(SB3, 16'h0000, 8'h00, TSB, "R10 sb3 accepted");
        rd(RDID, 16'h0061, 8'h03, "R3 sb3 readback");
        op(CFG, 16'h5500, 8'h00, TSEL, "R10 select while locked");
        // chip erase
        op(CE, 16'h0000, 8'h00, TCE, "R9 chip erase time");
        rd(RDID, 16'h0060, 8'h00, "R9 bits cleared");
        rd(RDID, 16'h0061, 8'h02, "R9 clk kept");
        rd(VFY, 16'h2010, 8'hFF, "R9 block0 erased");
        op(PB, 16'h0003, 8'h12, TPB, "R9 program after erase");
        op(CFG, 16'h5500, 8'h00, TSEL, "R5 select0");
        rd(VFY, 16'h0003, 8'hFF, "R9 went to block1");
        op(CFG, 16'hA500, 8'h00, TSEL, "R5 select1");
        rd(VFY, 16'h0003, 8'h12, "R9 block1 data");
        // exit and re-entry
        op(CFG, 16'h5500, 8'h00, TSEL, "R5 select0 before exit");
        @(negedge clk); mode_en_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(RDID, 16'h0030, 8'h00, "R1 outside mode");
        cmd = IDLE;
        @(negedge clk); mode_en_n = 1'b0;
        repeat (3) @(negedge clk);
        op(PB, 16'h0003, 8'h00, 0, "R1 arm dropped");
        arm();
        rd(VFY, 16'h0003, 8'h12, "R5 block1 default on entry");
        @(negedge clk); hold_rst = 1'b0;
        repeat (2) @(negedge clk);
        rd(RDID, 16'h0030, 8'h00, "R1 reset pin low exits");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule